// File: doc/BRIEF.md
# Undo-Redo Write-Ahead Log Unit

This unit watches the stores a core sends into its cache and, for each store whose address lies inside a configured persistent window, forms one log record. The record holds the store address, the value the cache line held before the store, the value being written, and the identifier of the current transaction. The prior value is taken from the write-allocated line before it is updated. A record that holds both values can be used to roll a transaction back or to replay it.

Records wait in a small on-chip queue. The queue drains toward a circular log region in nonvolatile memory when a transaction commits or when the queue fills. Drain writes leave in arrival order, one record per memory write handshake. The log region is not cached, so each record goes straight to the memory request port. A tail pointer marks the next free log slot and wraps at the end of the region. A head pointer marks the oldest live slot and moves forward when the consumer trims the log. The unit stalls the store stream when it cannot take a record, and it acknowledges a commit once every record queued before that commit has been accepted by memory.

Top module: `undo_redo_log`

## Requirements
- R1: A store with `st_valid` high and `PBASE <= st_addr < PBASE+PSIZE` that is not stalled produces exactly one record. A store outside that window produces no record and never raises `stall`.
- R2: `mem_req_data` is packed, from most significant to least significant bit, as {txid (TXW bits), address (AW), old value (DW), new value (DW)}. The txid field is the value `txid` held in the cycle the store was accepted.
- R3: When the queue reaches DEPTH records, draining starts in the next cycle without a commit and continues until the queue is empty.
- R4: Records leave in arrival order, one per cycle in which `mem_req_valid` and `mem_req_ready` are both high. While `mem_req_ready` is low, `mem_req_valid` stays high and the request does not change.
- R5: `tx_commit` starts a drain. `commit_ack` is high for exactly one cycle, the first cycle after the commit in which the queue is empty. While a commit is pending, persistent stores are stalled.
- R6: `stall` is high, and the store is dropped, when a persistent store arrives while the queue holds DEPTH records or a commit is pending.
- R7: Each record is written to `mem_req_addr = LOG_BASE + tail`, where tail is a slot index that starts at 0, advances by one per accepted write, and wraps from LOG_SLOTS-1 to 0.
- R8: No write is requested while advancing the tail would make it equal the head. Each `trim` pulse advances the head by one slot, with the same wrap, unless head equals tail.
- R9: `txid` resets to 0, increments on each `tx_begin`, and wraps modulo 2^TXW (256 by default).
- R10: After reset, `mem_req_valid`, `stall` and `commit_ack` are low and the queue and log are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A store is being snooped this cycle |
| st_addr | input | AW | Store address |
| st_old | input | DW | Line data before the store |
| st_new | input | DW | Data being stored |
| stall | output | 1 | Persistent store cannot be taken this cycle |
| tx_begin | input | 1 | Start of a new transaction |
| tx_commit | input | 1 | Current transaction completes |
| commit_ack | output | 1 | All records queued before the commit have been written |
| txid | output | TXW | Current transaction identifier |
| mem_req_valid | output | 1 | A log write is offered |
| mem_req_ready | input | 1 | Memory accepts the offered write |
| mem_req_addr | output | PW | Log slot address of the write |
| mem_req_data | output | TXW+AW+2*DW | Packed log record |
| trim | input | 1 | Release the oldest log slot (advance head) |

## Verification
A wrong queue pointer or count shows up in the first drain that follows. Either a record comes out of order or its packed fields differ, or `stall` rises one cycle early or late against the number of accepted stores. A tail or head that is off by one shows in the first `mem_req_addr` after the fault, or in the cycle where the log should block or free up. A commit-tracking error shows as an acknowledge in the wrong cycle. The bench keeps a queue-based model and compares every output on every clock, so each of these faults appears in the cycle it first reaches a port.

// File: rtl/undo_redo_log.sv
module undo_redo_log #(
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int TXW       = 8,
  parameter int DEPTH     = 8,
  parameter int PW        = 64,
  parameter int LOG_SLOTS = 1024,
  parameter logic [PW-1:0] LOG_BASE = '0,
  parameter logic [AW-1:0] PBASE    = '0,
  parameter logic [AW-1:0] PSIZE    = 4096,
  localparam int RW = TXW + AW + 2*DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_old,
  input  logic [DW-1:0] st_new,
  output logic          stall,
  input  logic          tx_begin,
  input  logic          tx_commit,
  output logic          commit_ack,
  output logic [TXW-1:0] txid,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [PW-1:0] mem_req_addr,
  output logic [RW-1:0] mem_req_data,
  input  logic          trim
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [PW-1:0] LAST  = PW'(LOG_SLOTS - 1);
  localparam logic [AW:0] P_LO = {1'b0, PBASE};
  localparam logic [AW:0] P_HI = {1'b0, PBASE} + {1'b0, PSIZE};

  logic [RW-1:0]  buf_q [DEPTH];
  logic [IW-1:0]  wr_q, rd_q;
  logic [CW-1:0]  cnt_q, cnt_nx;
  logic           flush_q, cpend_q;
  logic [PW-1:0]  head_q, tail_q, head_nx, tail_nx;
  logic [TXW-1:0] txid_q;

  logic pers, full, push, pop, log_full, log_empty;

  assign pers      = ({1'b0, st_addr} >= P_LO) && ({1'b0, st_addr} < P_HI);
  assign full      = (cnt_q == FULLC);
  assign stall     = st_valid & pers & (full | cpend_q);
  assign push      = st_valid & pers & ~full & ~cpend_q;

  assign tail_nx   = (tail_q == LAST) ? '0 : tail_q + 1'b1;
  assign head_nx   = (head_q == LAST) ? '0 : head_q + 1'b1;
  assign log_full  = (tail_nx == head_q);
  assign log_empty = (tail_q == head_q);

  assign mem_req_valid = (flush_q | cpend_q) & (cnt_q != '0) & ~log_full;
  assign mem_req_data  = buf_q[rd_q];
  assign mem_req_addr  = LOG_BASE + tail_q;
  assign pop           = mem_req_valid & mem_req_ready;

  assign commit_ack = cpend_q & (cnt_q == '0);
  assign txid       = txid_q;
  assign cnt_nx     = cnt_q + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (push) buf_q[wr_q] <= {txid_q, st_addr, st_old, st_new};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
      cpend_q <= 1'b0;
      head_q  <= '0;
      tail_q  <= '0;
      txid_q  <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop) begin
        rd_q   <= rd_q + 1'b1;
        tail_q <= tail_nx;
      end
      if (trim && !log_empty) head_q <= head_nx;
      cnt_q <= cnt_nx;
      if (tx_begin) txid_q <= txid_q + 1'b1;
      cpend_q <= tx_commit | (cpend_q & ~commit_ack);
      if (cnt_nx == FULLC)    flush_q <= 1'b1;
      else if (cnt_nx == '0)  flush_q <= 1'b0;
    end
  end
endmodule

// File: rtl/undo_redo_log_chk.sv
module undo_redo_log_chk #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int TXW = 8,
  parameter int PW = 64,
  parameter int LOG_SLOTS = 1024,
  parameter logic [AW-1:0] PBASE = '0,
  parameter logic [AW-1:0] PSIZE = 4096,
  localparam int RW = TXW + AW + 2*DW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           st_valid,
  input logic [AW-1:0]  st_addr,
  input logic           stall,
  input logic           tx_begin,
  input logic           tx_commit,
  input logic           commit_ack,
  input logic [TXW-1:0] txid,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic [PW-1:0]  mem_req_addr,
  input logic [RW-1:0]  mem_req_data,
  input logic [PW-1:0]  head_q,
  input logic [PW-1:0]  tail_q
);
  logic in_win;
  assign in_win = ({1'b0, st_addr} >= {1'b0, PBASE}) &&
                  ({1'b0, st_addr} < ({1'b0, PBASE} + {1'b0, PSIZE}));

  p_outside_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !in_win) |-> !stall);

  p_stall_needs_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> st_valid);

  p_hold_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_data) && $stable(mem_req_addr)));

  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ack && !tx_commit) |=> !commit_ack);

  p_ack_queue_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ack |-> !mem_req_valid);

  p_tail_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=>
      (tail_q == (($past(tail_q) == PW'(LOG_SLOTS - 1)) ? '0 : $past(tail_q) + 1'b1)));

  p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q < PW'(LOG_SLOTS)) && (head_q < PW'(LOG_SLOTS)));

  p_no_overtake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> (tail_q != head_q));

  p_txid_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_begin |=> (txid == $past(txid) + 1'b1));
endmodule

bind undo_redo_log undo_redo_log_chk #(
  .AW(AW), .DW(DW), .TXW(TXW), .PW(PW), .LOG_SLOTS(LOG_SLOTS),
  .PBASE(PBASE), .PSIZE(PSIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
  .stall(stall), .tx_begin(tx_begin), .tx_commit(tx_commit),
  .commit_ack(commit_ack), .txid(txid), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_req_data(mem_req_data), .head_q(head_q), .tail_q(tail_q)
);

// File: tb/undo_redo_log_bench.sv
module undo_redo_log_bench;
  localparam int AW = 16, DW = 16, TXW = 8, DEPTH = 4, PW = 64, SLOTS = 6;
  localparam logic [PW-1:0] LBASE = 64'h100;
  localparam logic [AW-1:0] PB = 16'h1000, PS = 16'h0100;
  localparam int RW = TXW + AW + 2*DW;

  logic clk = 0, rst_n = 0;
  logic st_valid = 0, tx_begin = 0, tx_commit = 0, mem_req_ready = 0, trim = 0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_old = '0, st_new = '0;
  logic stall, commit_ack, mem_req_valid;
  logic [TXW-1:0] txid;
  logic [PW-1:0] mem_req_addr;
  logic [RW-1:0] mem_req_data;

  always #5 clk = ~clk;

  undo_redo_log #(.AW(AW), .DW(DW), .TXW(TXW), .DEPTH(DEPTH), .PW(PW),
    .LOG_SLOTS(SLOTS), .LOG_BASE(LBASE), .PBASE(PB), .PSIZE(PS)) u_undo_redo_log (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_old(st_old), .st_new(st_new), .stall(stall), .tx_begin(tx_begin),
    .tx_commit(tx_commit), .commit_ack(commit_ack), .txid(txid),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data), .trim(trim));

  int checks = 0, failures = 0, cycles = 0;
  logic [RW-1:0] q[$];
  int m_head = 0, m_tail = 0;
  logic [TXW-1:0] m_txid = '0;
  bit m_cpend = 0, m_flush = 0;
  bit u_stall, u_valid, u_ack, u_lempty;

  function automatic bit inr(input logic [AW-1:0] a);
    return ({1'b0, a} >= {1'b0, PB}) && ({1'b0, a} < {1'b0, PB} + {1'b0, PS});
  endfunction
  function automatic int nxt(input int p);
    return (p == SLOTS - 1) ? 0 : p + 1;
  endfunction
  function automatic bit m_stall();
    return st_valid && inr(st_addr) && (q.size() == DEPTH || m_cpend);
  endfunction
  function automatic bit m_valid();
    return (m_flush || m_cpend) && q.size() > 0 && nxt(m_tail) != m_head;
  endfunction
  function automatic bit m_ack();
    return m_cpend && q.size() == 0;
  endfunction

  task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete(); m_head = 0; m_tail = 0; m_txid = '0; m_cpend = 0; m_flush = 0;
    end else begin
      u_stall = m_stall(); u_valid = m_valid(); u_ack = m_ack();
      u_lempty = (m_head == m_tail);
      if (u_valid && mem_req_ready) begin void'(q.pop_front()); m_tail = nxt(m_tail); end
      if (trim && !u_lempty) m_head = nxt(m_head);
      if (st_valid && inr(st_addr) && !u_stall) q.push_back({m_txid, st_addr, st_old, st_new});
      if (tx_begin) m_txid = m_txid + 1'b1;
      m_cpend = tx_commit || (m_cpend && !u_ack);
      if (q.size() == DEPTH) m_flush = 1; else if (q.size() == 0) m_flush = 0;
    end
  end

  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      chk("R1 R6 stall", RW'(stall), RW'(m_stall()));
      chk("R1 R3 R4 R8 mem_req_valid", RW'(mem_req_valid), RW'(m_valid()));
      chk("R5 commit_ack", RW'(commit_ack), RW'(m_ack()));
      chk("R9 txid", RW'(txid), RW'(m_txid));
      if (m_valid()) begin
        chk("R2 R4 mem_req_data", mem_req_data, q[0]);
        chk("R7 mem_req_addr", RW'(mem_req_addr), RW'(LBASE + PW'(m_tail)));
      end
    end
  end

  task automatic drive(input bit sv, input logic [AW-1:0] a, input bit beg,
                       input bit com, input bit rdy, input bit tr);
    @(negedge clk);
    st_valid = sv; st_addr = a; st_old = DW'($urandom); st_new = DW'($urandom);
    tx_begin = beg; tx_commit = com; mem_req_ready = rdy; trim = tr;
  endtask
  task automatic idle(input int n, input bit rdy);
    for (int i = 0; i < n; i++) drive(0, '0, 0, 0, rdy, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [TXW-1:0] t0;
    idle(3, 0);
    @(negedge clk); rst_n = 1;
    #4;
    chk("R10 reset valid", RW'(mem_req_valid), '0);
    chk("R10 reset stall", RW'(stall), '0);
    chk("R10 reset ack", RW'(commit_ack), '0);
    chk("R10 reset txid", RW'(txid), '0);

    // R1 R2 R4 R5: mixed stores, commit, drain with ready
    drive(0, '0, 1, 0, 0, 0);
    drive(1, PB, 0, 0, 0, 0);
    drive(1, PB - 1, 0, 0, 0, 0);
    drive(1, PB + PS - 1, 0, 0, 0, 0);
    drive(1, PB + PS, 0, 0, 0, 0);
    drive(1, PB + 16'h40, 0, 0, 0, 0);
    drive(0, '0, 0, 1, 0, 0);
    idle(2, 0);
    drive(1, PB + 2, 0, 0, 0, 0);
    #4; chk("R5 stall while commit pending", RW'(stall), 1);
    idle(6, 1);
    for (int i = 0; i < 3; i++) drive(0, '0, 0, 0, 0, 1);

    // R3 R6: fill queue without commit, backpressure
    for (int i = 0; i < DEPTH; i++) drive(1, PB + AW'(i), 0, 0, 0, 0);
    drive(1, PB + 16'h20, 0, 0, 0, 0);
    #4;
    chk("R3 drain on full", RW'(mem_req_valid), 1);
    chk("R6 stall on full", RW'(stall), 1);
    idle(3, 0);
    idle(6, 1);

    // R8: log fills, writes blocked until trim
    for (int i = 0; i < DEPTH; i++) drive(1, PB + 16'h30 + AW'(i), 0, 0, 1, 0);
    idle(4, 1);
    #4; chk("R8 log full blocks write", RW'(mem_req_valid), 0);
    for (int i = 0; i < 6; i++) drive(0, '0, 0, 0, 1, 1);
    idle(6, 1);
    for (int i = 0; i < 6; i++) drive(0, '0, 0, 0, 1, 1);

    // R9: txid wrap
    t0 = txid;
    for (int i = 0; i < 256; i++) drive(0, '0, 1, 0, 1, 0);
    idle(1, 1);
    #4; chk("R9 txid wraps", RW'(txid), RW'(t0));

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      drive(r < 50, PB - 16'h8 + AW'($urandom_range(0, 16'h110)),
            $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
            $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0);
    end
    for (int i = 0; i < 30; i++) drive(0, '0, 0, 0, 1, 1);
    idle(2, 1);
    finish_run();
  end
endmodule